// File: doc/BRIEF.md
# Split-Write Command Queue

This block accepts 32-bit commands from a 16-bit register bus and hands them, oldest first, to a command consumer through a valid/ready interface. A command is written in two halves. Software first writes the upper half to the high-half register. It then writes the lower half to the low-half register, and that second write pushes the joined 32-bit word into an internal queue.

Software learns how much room is left by reading the pending count, and it learns the capacity from the size output. The pending count holds every command that the consumer has not yet accepted, including the one presented at the consumer port. Before a burst of N commands, software waits until the count is at most capacity minus N. To synchronise with the consumer, it waits until the count is zero.

A clear write discards everything still queued. A push that finds the queue full is lost and sets a sticky overflow flag. The same clear write also resets that flag.

Top module: `cmdq_split_top`

## Requirements
- R1: After reset the pending count is 0, `cmd_valid` is 0 and `q_overflow` is 0.
- R2: `q_size` always equals the capacity minus one (DEPTH-1).
- R3: A bus write with `reg_sel`=2'b00 latches `reg_wdata` as the high half. A write with `reg_sel`=2'b01 pushes {latched high half, `reg_wdata`} into the queue. The pending count rises by one on the clock edge that takes the write.
- R4: A low-half write that is not preceded by a new high-half write reuses the high half latched most recently.
- R5: Commands leave at `cmd_data` in the order they were pushed.
- R6: The pending count equals accepted pushes minus completed pops (`cmd_valid` and `cmd_ready` both 1). A command presented but not yet accepted is counted. A push and a pop in the same cycle leave the count unchanged.
- R7: A push arriving while the count equals DEPTH is dropped. The count and the queue contents stay as they were, and `q_overflow` becomes 1. The flag stays at 1 until it is cleared.
- R8: A write with `reg_sel`=2'b10 and `reg_wdata[0]`=1 empties the queue and sets the count to 0 and `q_overflow` to 0 on the next edge. With `reg_wdata[0]`=0 the same write changes nothing.
- R9: A write with `reg_sel`=2'b11 has no effect on the queue, the count or the outputs.
- R10: `cmd_valid` is 1 exactly when the pending count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 00 high half, 01 low half and push, 10 clear, 11 unused |
| reg_wdata | input | 16 | Register write data |
| cmd_valid | output | 1 | A command is presented to the consumer |
| cmd_ready | input | 1 | Consumer accepts the presented command |
| cmd_data | output | 32 | Oldest pending command |
| q_count | output | $clog2(DEPTH+1) | Commands pending, including the presented one |
| q_size | output | $clog2(DEPTH+1) | Capacity minus one |
| q_overflow | output | 1 | Sticky flag set by a dropped push |

## Verification
The bench builds the queue with DEPTH=8 rather than the default 512. With that depth, the full condition, the dropped ninth push and the pointer wrap-around are reached in a few dozen cycles. The same depth lets the bench check every entry of a full drain to confirm that the dropped word never appears. The 16-bit halves keep their default width, so the way the register bus splits a command is the same as in the full-size build.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  typedef enum logic [1:0] {
    SEL_HI   = 2'b00,
    SEL_LO   = 2'b01,
    SEL_CLR  = 2'b10,
    SEL_NONE = 2'b11
  } cmdq_sel_e;

  // joins the two bus halves into one queue word
  function automatic logic [31:0] cmdq_join(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  // a clear write only acts when bit 0 of the data is set
  function automatic logic cmdq_is_clear(input logic [1:0] sel, input logic [15:0] data);
    return (sel == SEL_CLR) && data[0];
  endfunction
endpackage

// File: rtl/cmdq_assemble.sv
module cmdq_assemble
  import cmdq_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic              push_req,
  output logic              clr_req,
  output logic [2*HALF_W-1:0] push_word
);
  logic [HALF_W-1:0] hi_q;
  logic              hi_wr;

  assign hi_wr     = reg_wr && (reg_sel == SEL_HI);
  assign push_req  = reg_wr && (reg_sel == SEL_LO);
  assign clr_req   = reg_wr && cmdq_is_clear(reg_sel, reg_wdata);
  assign push_word = cmdq_join(hi_q, reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_wr) hi_q <= reg_wdata;
  end

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(hi_q)); // R4
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> (hi_q == $past(reg_wdata))); // R3
endmodule

// File: rtl/cmdq_level.sv
module cmdq_level #(
  parameter int DEPTH = 512,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop,
  input  logic             clr,
  output logic             push_ok,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic full;
  logic drop;

  assign full    = (count == FULL_LVL);
  assign push_ok = push_req && !full;
  assign drop    = push_req && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count + CNT_W'(push_ok) - CNT_W'(pop);
      if (drop) ovf <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_LVL); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R7
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop && !clr) |=> (count == FULL_LVL) && ovf); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !ovf); // R8
  AST_PUSH_POP_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop && !clr) |=> $stable(count)); // R6
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  input  logic              clr,
  output logic              nonempty,
  output logic [WORD_W-1:0] head_word
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr;
  logic [AW:0]       rd_ptr;

  assign nonempty  = (wr_ptr != rd_ptr);
  assign head_word = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr[AW-1:0]] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |=> (rd_ptr == $past(rd_ptr) + 1'b1)); // R5
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty); // R10
endmodule

// File: rtl/cmdq_split_top.sv
module cmdq_split_top
  import cmdq_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [WORD_W-1:0] cmd_data,
  output logic [CNT_W-1:0]  q_count,
  output logic [CNT_W-1:0]  q_size,
  output logic              q_overflow
);
  logic              push_req;
  logic              push_ok;
  logic              clr_req;
  logic              pop;
  logic [WORD_W-1:0] push_word;

  assign pop    = cmd_valid && cmd_ready;
  assign q_size = CNT_W'(DEPTH - 1);

  cmdq_assemble #(.HALF_W(HALF_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .push_req(push_req), .clr_req(clr_req),
    .push_word(push_word)
  );

  cmdq_level #(.DEPTH(DEPTH)) u_lvl (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop(pop),
    .clr(clr_req), .push_ok(push_ok), .count(q_count), .ovf(q_overflow)
  );

  cmdq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .push_word(push_word),
    .pop(pop), .clr(clr_req), .nonempty(cmd_valid), .head_word(cmd_data)
  );

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid == (q_count != '0)); // R10
  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_NONE && !pop) |=> $stable(q_count)); // R9
  AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop && !clr_req) |=> (q_count == $past(q_count) + 1'b1)); // R3
endmodule

// File: tb/test_cmdq_split_top.sv
module test_cmdq_split_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic [CNT_W-1:0] q_count;
  logic [CNT_W-1:0] q_size;
  logic        q_overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmdq_split_top #(.DEPTH(DEPTH)) i_cmdq_split_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .q_count(q_count), .q_size(q_size),
    .q_overflow(q_overflow)
  );

  // stimulus and expected result: sel, data, count after, head after (0 = not checked)
  localparam logic [57:0] VECS [0:6] = '{
    {2'b00, 16'hA1B2, 8'd0, 32'h0000_0000},   // R3 high half only
    {2'b01, 16'h0001, 8'd1, 32'hA1B2_0001},   // R3 push
    {2'b01, 16'h0002, 8'd2, 32'hA1B2_0001},   // R4 reuse high
    {2'b00, 16'h1234, 8'd2, 32'hA1B2_0001},   // R3
    {2'b01, 16'h5678, 8'd3, 32'hA1B2_0001},   // R3
    {2'b11, 16'hFFFF, 8'd3, 32'hA1B2_0001},   // R9 unused select
    {2'b10, 16'h0000, 8'd3, 32'hA1B2_0001}    // R8 clear without bit 0
  };

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pop_check(input logic [31:0] exp, input string req);
    @(negedge clk);
    cmd_ready = 1'b1;
    check(cmd_valid && cmd_data == exp, req, cmd_data, exp);
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(q_count == 0, "R1 count", 32'(q_count), 0);
    check(!cmd_valid, "R1 valid", 32'(cmd_valid), 0);
    check(!q_overflow, "R1 overflow", 32'(q_overflow), 0);
    check(q_size == CNT_W'(DEPTH - 1), "R2 size", 32'(q_size), DEPTH - 1);

    foreach (VECS[i]) begin
      bus_write(VECS[i][57:56], VECS[i][55:40]);
      check(q_count == CNT_W'(VECS[i][39:32]), "R6 table count", 32'(q_count), 32'(VECS[i][39:32]));
      check(cmd_valid == (VECS[i][39:32] != 0), "R10 table valid", 32'(cmd_valid), 32'(VECS[i][39:32] != 0));
      if (VECS[i][39:32] != 0)
        check(cmd_data == VECS[i][31:0], "R3 table head", cmd_data, VECS[i][31:0]);
    end

    // R5 order
    pop_check(32'hA1B2_0001, "R5 first");
    pop_check(32'hA1B2_0002, "R5 second");
    pop_check(32'h1234_5678, "R5 third");
    check(q_count == 0 && !cmd_valid, "R10 drained", 32'(q_count), 0);

    // R7 fill, overflow and sticky flag
    bus_write(2'b00, 16'hC0DE);
    for (int i = 0; i < DEPTH; i++) bus_write(2'b01, 16'(16'h0100 + i));
    check(q_count == CNT_W'(DEPTH) && !q_overflow, "R7 full no flag", 32'(q_count), DEPTH);
    bus_write(2'b01, 16'hDEAD);
    check(q_count == CNT_W'(DEPTH), "R7 drop count", 32'(q_count), DEPTH);
    check(q_overflow, "R7 flag set", 32'(q_overflow), 1);
    pop_check(32'hC0DE_0100, "R7 head kept");
    check(q_overflow && q_count == CNT_W'(DEPTH - 1), "R7 sticky", 32'(q_count), DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) pop_check(32'hC0DE_0100 + 32'(i), "R7 contents");
    check(q_count == 0, "R6 empty after drain", 32'(q_count), 0);

    // R8 clear with bit 0 set
    bus_write(2'b01, 16'h0AA0);
    bus_write(2'b01, 16'h0AA1);
    bus_write(2'b10, 16'h0001);
    check(q_count == 0 && !cmd_valid, "R8 cleared", 32'(q_count), 0);
    check(!q_overflow, "R8 flag cleared", 32'(q_overflow), 0);

    // R6 push and pop in the same cycle
    bus_write(2'b01, 16'h0AAA);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'b01; reg_wdata = 16'h0BBB; cmd_ready = 1'b1;
    check(cmd_data == 32'hC0DE_0AAA, "R6 head before", cmd_data, 32'hC0DE_0AAA);
    @(negedge clk);
    reg_wr = 1'b0; cmd_ready = 1'b0;
    check(q_count == 1, "R6 same cycle count", 32'(q_count), 1);
    check(cmd_data == 32'hC0DE_0BBB, "R6 new head", cmd_data, 32'hC0DE_0BBB);

    // R9 unused select leaves state alone
    bus_write(2'b11, 16'h0001);
    check(q_count == 1 && cmd_data == 32'hC0DE_0BBB, "R9 no effect", cmd_data, 32'hC0DE_0BBB);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule